// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Command Sequencer

This block owns the command pins of a registered single-data-rate SDRAM array clocked at 133 MHz. After reset it waits out the power-up interval while driving only NOP with the clock enable high. It then precharges every bank and runs a fixed burst of auto-refreshes. Last, it loads the mode register with CAS latency 3 and the burst length, wrap type and write-burst mode taken from its configuration pins. When that is finished it raises `init_done`.

From then on an internal interval timer asks for periodic auto-refresh. A read/write engine shares the command pins with this block through a level handshake. The sequencer raises `ref_req`. The engine closes its work and answers with `ref_ack`, and also reports whether any bank is still open. Once the ack has been sampled, the engine keeps off the command pins until `ref_req` falls. If a whole interval passes while a request is still waiting, the next grant issues a back-to-back catch-up burst of refreshes. The same handshake serves self-refresh. Holding `sr_req` high makes the block take the bus, put the array into self-refresh, and keep it there. When `sr_req` falls, the block raises the clock enable, waits out the exit, and only then hands the bus back. No data flows through the block, so it has no valid/ready stream. All of its pins are plain control and status.

Top module: `sdram_init_refresh_seq`

## Requirements
- R1: After reset release the clock enable stays high and only NOP is driven for at least T_POWERUP cycles. The first command, a precharge-all, appears no later than T_POWERUP+2 cycles after release.
- R2: The initialization order is one precharge-all, then INIT_REFS auto-refreshes, then one mode register set. The first refresh comes T_RP cycles after the precharge. Each later refresh, and the mode register set, comes T_RC cycles after the refresh before it. `init_done` rises T_MRD cycles after the mode register set and never falls until reset.
- R3: During the mode register set, the bank address is 0 and the address lines carry the following fields. A2:A0 is `mode_bl`, where the codes are 000 for 1, 001 for 2, 010 for 4, 011 for 8 and 111 for full page. A3 is `mode_interleave`. A6:A4 is the CAS latency, 011 for 3. A9 is `mode_single_wr`. All other address bits are 0. Every precharge-all drives A10 = 1.
- R4: The commands are encoded on {cs_n, ras_n, cas_n, we_n} as follows. NOP is 0111. Precharge is 0010. Auto-refresh is 0001. Mode register set is 0000. Self-refresh entry is 0001 with the clock enable low in the same cycle.
- R5: No command of any kind follows an auto-refresh within T_RC cycles.
- R6: `ref_req` first rises between REF_INTERVAL and REF_INTERVAL+2 cycles after `init_done` rises. While `ref_req` is high and no ack has been sampled, no command is driven.
- R7: When `ref_ack` is sampled high with `banks_open` low, the first auto-refresh appears 2 cycles after the ack cycle. With `banks_open` high, a precharge-all appears 1 cycle after the ack cycle, and the refresh follows T_RP cycles after that precharge.
- R8: `ref_req` falls exactly T_RC cycles after the last auto-refresh of a granted refresh service.
- R9: If a further refresh interval expires while a request is still unserved, the next grant issues CATCHUP (2) auto-refreshes, spaced T_RC apart. The grant after that returns to a single refresh.
- R10: When the block is granted while `sr_req` is high and no refresh is pending, self-refresh entry appears 2 cycles after the ack cycle. The clock enable then stays low, with only NOP driven, for as long as `sr_req` stays high.
- R11: The clock enable rises 1 cycle after the cycle in which `sr_req` is first seen low. `ref_req` falls SR_EXIT_EDGES+T_RC cycles after that rise, with no command in between. The refresh timer restarts at that release, so the next `ref_req` rises between REF_INTERVAL and REF_INTERVAL+2 cycles later.
- R12: Once `init_done` is high, a command is driven only while `ref_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_bl | input | 3 | Burst length code placed on A2:A0 |
| mode_interleave | input | 1 | Wrap type for A3 (1 = interleaved) |
| mode_single_wr | input | 1 | Write-burst mode for A9 (1 = single-location writes) |
| ref_ack | input | 1 | Engine grants the command bus with all work closed |
| banks_open | input | 1 | At least one bank left open, sampled with the ack |
| sr_req | input | 1 | Level request to hold the array in self-refresh |
| ref_req | output | 1 | Sequencer wants or owns the command bus |
| init_done | output | 1 | Power-up sequence complete |
| sd_cke | output | 1 | Clock enable to the array |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | ADDR_W | Address lines |

## Verification
Every cycle, the assertions check the spacing rule after each refresh and the quiet power-up window. They also check that `init_done` never falls, that no command leaves while the bus belongs to the engine, that the clock enable stays low only with NOP, and that the backlog and timer flags stay consistent. Some behaviour is visible only in the bench scenarios: the exact order and cycle positions of the init commands, the mode word across the sweep of burst codes and wrap types, and the ack-to-command latencies with and without open banks. The same holds for the catch-up burst after a missed interval and the full self-refresh exit timing with the timer restart.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [3:0] {
    ST_BOOT,
    ST_INIT_REF,
    ST_IDLE,
    ST_GRANT,
    ST_SVC,
    ST_SELF,
    ST_WAKE
  } seq_state_e;

  function automatic logic [11:0] mode_word(input logic [2:0] bl, input logic wrap,
                                            input logic wb, input logic [2:0] cl);
    logic [11:0] w;
    w      = '0;
    w[2:0] = bl;
    w[3]   = wrap;
    w[6:4] = cl;
    w[9]   = wb;
    return w;
  endfunction

endpackage

// File: rtl/sdr_ref_timer.sv
module sdr_ref_timer #(
  parameter int INTERVAL = 2080
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int CW = $clog2(INTERVAL + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CW'(INTERVAL - 1);
      tick  <= 1'b0;
    end else if (restart) begin
      cnt_q <= CW'(INTERVAL - 1);
      tick  <= 1'b0;
    end else if (run) begin
      if (cnt_q == '0) begin
        cnt_q <= CW'(INTERVAL - 1);
        tick  <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
        tick  <= 1'b0;
      end
    end else begin
      tick <= 1'b0;
    end
  end

  assert_tick_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (INTERVAL > 1)) |=> !tick);

  assert_tick_quiet_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);

endmodule

// File: rtl/sdr_ref_backlog.sv
module sdr_ref_backlog (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic take,
  input  logic drop,
  output logic pend,
  output logic overdue
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      overdue <= 1'b0;
    end else if (take) begin
      pend    <= tick;
      overdue <= 1'b0;
    end else if (drop) begin
      pend    <= 1'b0;
      overdue <= 1'b0;
    end else if (tick) begin
      overdue <= overdue | pend;
      pend    <= 1'b1;
    end
  end

  assert_overdue_implies_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overdue |-> pend);

endmodule

// File: rtl/sdram_init_refresh_seq.sv
module sdram_init_refresh_seq
  import sdr_seq_pkg::*;
#(
  parameter int ADDR_W        = 12,
  parameter int T_POWERUP     = 13334,
  parameter int T_RP          = 3,
  parameter int T_RC          = 8,
  parameter int T_MRD         = 2,
  parameter int INIT_REFS     = 8,
  parameter int REF_INTERVAL  = 2080,
  parameter int CATCHUP       = 2,
  parameter int SR_EXIT_EDGES = 2,
  parameter int CAS_LAT       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_bl,
  input  logic              mode_interleave,
  input  logic              mode_single_wr,
  input  logic              ref_ack,
  input  logic              banks_open,
  input  logic              sr_req,
  output logic              ref_req,
  output logic              init_done,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [1:0]        sd_ba,
  output logic [ADDR_W-1:0] sd_addr
);
  localparam int WAIT_W = $clog2(T_POWERUP + T_RP + T_RC + T_MRD + SR_EXIT_EDGES + 2);
  localparam int RL_W   = $clog2(INIT_REFS + CATCHUP + 2);
  localparam int GAP_W  = $clog2(T_RC + 2);
  localparam int AP_BIT = 10;

  seq_state_e        state;
  logic [WAIT_W-1:0] wait_q;
  logic [RL_W-1:0]   refs_left;
  sdr_cmd_e          cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        ba_q;
  logic              cke_q;
  logic              init_done_q;
  logic              ref_req_q;

  logic tick, pend, overdue, take, drop, in_sr, pend_now;

  assign in_sr    = (state == ST_SELF) || (state == ST_WAKE);
  assign take     = (state == ST_GRANT) && (wait_q == '0) && ref_ack;
  assign drop     = (state == ST_SVC) && (wait_q == '0) && (refs_left == '0) && sr_req;
  assign pend_now = pend | tick;

  sdr_ref_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(init_done_q), .restart(in_sr), .tick(tick)
  );

  sdr_ref_backlog u_backlog (
    .clk(clk), .rst_n(rst_n), .tick(tick), .take(take), .drop(drop),
    .pend(pend), .overdue(overdue)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_BOOT;
      wait_q      <= WAIT_W'(T_POWERUP);
      refs_left   <= '0;
      cmd_q       <= CMD_NOP;
      addr_q      <= '0;
      ba_q        <= '0;
      cke_q       <= 1'b1;
      init_done_q <= 1'b0;
      ref_req_q   <= 1'b0;
    end else begin
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      ba_q   <= '0;
      if (wait_q != '0) begin
        wait_q <= wait_q - 1'b1;
      end else begin
        case (state)
          ST_BOOT: begin
            cmd_q          <= CMD_PRE;
            addr_q[AP_BIT] <= 1'b1;
            wait_q         <= WAIT_W'(T_RP - 1);
            refs_left      <= RL_W'(INIT_REFS);
            state          <= ST_INIT_REF;
          end
          ST_INIT_REF: begin
            if (refs_left != '0) begin
              cmd_q     <= CMD_REF;
              refs_left <= refs_left - 1'b1;
              wait_q    <= WAIT_W'(T_RC - 1);
            end else begin
              cmd_q  <= CMD_MRS;
              addr_q <= ADDR_W'(mode_word(mode_bl, mode_interleave, mode_single_wr,
                                          3'(CAS_LAT)));
              wait_q <= WAIT_W'(T_MRD - 1);
              state  <= ST_IDLE;
            end
          end
          ST_IDLE: begin
            init_done_q <= 1'b1;
            if (init_done_q && (pend_now || sr_req)) begin
              ref_req_q <= 1'b1;
              state     <= ST_GRANT;
            end
          end
          ST_GRANT: begin
            if (ref_ack) begin
              refs_left <= overdue ? RL_W'(CATCHUP) : (pend ? RL_W'(1) : '0);
              if (banks_open) begin
                cmd_q          <= CMD_PRE;
                addr_q[AP_BIT] <= 1'b1;
                wait_q         <= WAIT_W'(T_RP - 1);
              end
              state <= ST_SVC;
            end
          end
          ST_SVC: begin
            if (refs_left != '0) begin
              cmd_q     <= CMD_REF;
              refs_left <= refs_left - 1'b1;
              wait_q    <= WAIT_W'(T_RC - 1);
            end else if (sr_req) begin
              cmd_q <= CMD_REF;
              cke_q <= 1'b0;
              state <= ST_SELF;
            end else begin
              ref_req_q <= 1'b0;
              state     <= ST_IDLE;
            end
          end
          ST_SELF: begin
            if (!sr_req) begin
              cke_q  <= 1'b1;
              wait_q <= WAIT_W'(SR_EXIT_EDGES + T_RC - 1);
              state  <= ST_WAKE;
            end
          end
          ST_WAKE: begin
            ref_req_q <= 1'b0;
            state     <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_addr   = addr_q;
  assign sd_ba     = ba_q;
  assign sd_cke    = cke_q;
  assign init_done = init_done_q;
  assign ref_req   = ref_req_q;

  // Checker state: cycles since reset and since the last refresh on the pins
  logic [WAIT_W-1:0] boot_cnt;
  logic [GAP_W-1:0]  gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_cnt <= '0;
      gap_q    <= GAP_W'(T_RC);
    end else begin
      if (boot_cnt < WAIT_W'(T_POWERUP)) boot_cnt <= boot_cnt + 1'b1;
      if (cmd_q == CMD_REF) gap_q <= GAP_W'(1);
      else if (gap_q < GAP_W'(T_RC)) gap_q <= gap_q + 1'b1;
    end
  end

  assert_quiet_powerup_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != CMD_NOP) |-> (boot_cnt >= WAIT_W'(T_POWERUP)));

  assert_cke_high_powerup_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_cnt < WAIT_W'(T_POWERUP)) |-> cke_q);

  assert_init_done_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(init_done_q));

  assert_refresh_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != CMD_NOP) |-> (gap_q >= GAP_W'(T_RC)));

  assert_cke_low_nop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_q && $past(!cke_q)) |-> (cmd_q == CMD_NOP));

  assert_bus_owned_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done_q && (cmd_q != CMD_NOP)) |-> ref_req_q);

endmodule

// File: tb/sdram_init_refresh_seq_test.sv
module sdram_init_refresh_seq_test;
  localparam int TP = 20, TRP = 3, TRC = 8, TMRD = 2, NREF = 8;
  localparam int INTV = 60, CATCH = 2, EXITE = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode_bl = 3'd0;
  logic mode_interleave = 1'b0, mode_single_wr = 1'b0;
  logic ref_ack = 1'b0, banks_open = 1'b0, sr_req = 1'b0;
  logic ref_req, init_done, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0] sd_ba;
  logic [11:0] sd_addr;

  sdram_init_refresh_seq #(
    .ADDR_W(12), .T_POWERUP(TP), .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD),
    .INIT_REFS(NREF), .REF_INTERVAL(INTV), .CATCHUP(CATCH),
    .SR_EXIT_EDGES(EXITE), .CAS_LAT(3)
  ) uut (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0, wd = 0, cyc = 0;
  int n_log = 0;
  logic [3:0]  lg_cmd [64];
  logic [11:0] lg_addr[64];
  logic        lg_cke [64];
  int          lg_cyc [64];
  int init_rise, rq_rise, rq_fall, cke_rise, cke_fall, last_ref, bad5, bad12;
  logic prev_init, prev_rq, prev_cke;
  logic [3:0] cmd;
  assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd != 4'b0111) begin
        if (n_log < 64) begin
          lg_cmd[n_log] = cmd; lg_addr[n_log] = sd_addr;
          lg_cke[n_log] = sd_cke; lg_cyc[n_log] = cyc;
        end
        n_log = n_log + 1;
        if (last_ref >= 0 && cyc - last_ref < TRC) bad5 = bad5 + 1;
        if (init_done && !ref_req) bad12 = bad12 + 1;
        if (cmd == 4'b0001) last_ref = cyc;
      end
      if (init_done && !prev_init) init_rise = cyc;
      if (ref_req && !prev_rq) rq_rise = cyc;
      if (!ref_req && prev_rq) rq_fall = cyc;
      if (sd_cke && !prev_cke) cke_rise = cyc;
      if (!sd_cke && prev_cke) cke_fall = cyc;
      prev_init = init_done; prev_rq = ref_req; prev_cke = sd_cke;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    wd = wd + 1;
    if (wd > 150000) begin
      checks = checks + 1; fails = fails + 1;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 150000);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rq(input logic v, input int lim);
    int k = 0;
    while (ref_req !== v && k < lim) begin @(negedge clk); k++; end
  endtask

  task automatic do_reset(input logic [2:0] bl, input logic wr, input logic wb);
    @(negedge clk);
    rst_n = 1'b0; ref_ack = 0; banks_open = 0; sr_req = 0;
    mode_bl = bl; mode_interleave = wr; mode_single_wr = wb;
    n_log = 0; init_rise = -1; rq_rise = -1; rq_fall = -1; cke_rise = -1;
    cke_fall = -1; last_ref = -1; bad5 = 0; bad12 = 0;
    prev_init = 0; prev_rq = 0; prev_cke = 1;
    step(3);
    rst_n = 1'b1;
  endtask

  task automatic grant(input logic open_banks, output int a);
    a = cyc; ref_ack = 1'b1; banks_open = open_banks;
    step(1);
    ref_ack = 1'b0; banks_open = 1'b0;
  endtask

  initial begin
    int a, n0, r, d, sr_idx;
    logic [2:0] bls [5];
    bls[0] = 3'b000; bls[1] = 3'b001; bls[2] = 3'b010; bls[3] = 3'b011; bls[4] = 3'b111;

    // Reset state
    rst_n = 1'b0;
    step(2);
    check(sd_cke === 1'b1 && cmd === 4'b0111 && init_done === 1'b0 && ref_req === 1'b0,
          "R1 reset state", {sd_cke, cmd, init_done, ref_req}, 7'b1011100);

    // Init sequence and mode word swept over burst codes and wrap types
    for (int b = 0; b < 5; b++) begin
      for (int w = 0; w < 2; w++) begin
        logic wb;
        bit ok;
        int exp_mode;
        wb = logic'(w) ^ bls[b][0];
        do_reset(bls[b], logic'(w), wb);
        step(TP + TRP + NREF * TRC + TMRD + 10);
        check(n_log >= 1 && lg_cmd[0] == 4'b0010 && lg_cyc[0] >= TP && lg_cyc[0] <= TP + 2
              && cke_fall == -1, "R1 first command after power-up wait", lg_cyc[0], TP + 1);
        ok = (n_log == NREF + 2) && lg_cmd[0] == 4'b0010;
        for (int i = 1; i <= NREF; i++)
          ok = ok && lg_cmd[i] == 4'b0001 && lg_cke[i]
               && (lg_cyc[i] - lg_cyc[i-1] == ((i == 1) ? TRP : TRC));
        ok = ok && lg_cmd[NREF+1] == 4'b0000 && (lg_cyc[NREF+1] - lg_cyc[NREF] == TRC);
        check(ok, "R2 R4 init order and spacing", n_log, NREF + 2);
        check(init_rise == lg_cyc[NREF+1] + TMRD && init_done === 1'b1,
              "R2 init_done timing", init_rise, lg_cyc[NREF+1] + TMRD);
        exp_mode = (int'(wb) << 9) | (3 << 4) | (w << 3) | int'(bls[b]);
        check(lg_addr[NREF+1] == 12'(exp_mode) && lg_addr[0][10] == 1'b1 && sd_ba == 2'b00,
              "R3 mode word", int'(lg_addr[NREF+1]), exp_mode);
      end
    end

    // Periodic refresh with a late ack, no open banks
    wait_rq(1'b1, 200); step(1);
    check(rq_rise >= init_rise + INTV && rq_rise <= init_rise + INTV + 2,
          "R6 first refresh request", rq_rise - init_rise, INTV + 1);
    n0 = n_log;
    step(5);
    check(n_log == n0, "R6 quiet until ack", n_log, n0);
    grant(1'b0, a);
    wait_rq(1'b0, 100); step(1);
    check(n_log == n0 + 1 && lg_cmd[n0] == 4'b0001 && lg_cyc[n0] == a + 2,
          "R7 refresh after ack", lg_cyc[n0], a + 2);
    check(rq_fall == lg_cyc[n0] + TRC, "R8 release after refresh", rq_fall, lg_cyc[n0] + TRC);

    // Refresh with banks left open
    wait_rq(1'b1, 200); step(1);
    n0 = n_log;
    grant(1'b1, a);
    wait_rq(1'b0, 100); step(1);
    check(n_log == n0 + 2 && lg_cmd[n0] == 4'b0010 && lg_addr[n0][10] == 1'b1
          && lg_cyc[n0] == a + 1, "R7 precharge before refresh", lg_cyc[n0], a + 1);
    check(lg_cmd[n0+1] == 4'b0001 && lg_cyc[n0+1] == lg_cyc[n0] + TRP,
          "R7 refresh after precharge", lg_cyc[n0+1] - lg_cyc[n0], TRP);
    check(rq_fall == lg_cyc[n0+1] + TRC, "R8 release after open-bank service",
          rq_fall, lg_cyc[n0+1] + TRC);

    // Missed interval forces catch-up
    wait_rq(1'b1, 200); step(1);
    n0 = n_log;
    step(INTV + 30);
    check(n_log == n0, "R6 quiet during long wait", n_log, n0);
    grant(1'b0, a);
    wait_rq(1'b0, 100); step(1);
    check(n_log == n0 + CATCH && lg_cmd[n0] == 4'b0001 && lg_cmd[n0+1] == 4'b0001,
          "R9 catch-up count", n_log - n0, CATCH);
    check(lg_cyc[n0] == a + 2 && lg_cyc[n0+1] - lg_cyc[n0] == TRC,
          "R9 catch-up spacing", lg_cyc[n0+1] - lg_cyc[n0], TRC);
    check(rq_fall == lg_cyc[n0+1] + TRC, "R8 release after catch-up",
          rq_fall, lg_cyc[n0+1] + TRC);

    // Next grant is back to one refresh
    wait_rq(1'b1, 200); step(1);
    n0 = n_log;
    grant(1'b0, a);
    wait_rq(1'b0, 100); step(1);
    check(n_log == n0 + 1, "R9 backlog cleared", n_log - n0, 1);

    // Self-refresh entry and exit
    sr_req = 1'b1;
    wait_rq(1'b1, 20); step(1);
    n0 = n_log;
    grant(1'b0, a);
    step(20);
    sr_idx = n0;
    check(n_log == n0 + 1 && lg_cmd[sr_idx] == 4'b0001 && lg_cke[sr_idx] == 1'b0
          && lg_cyc[sr_idx] == a + 2, "R10 R4 self-refresh entry", lg_cyc[sr_idx], a + 2);
    check(sd_cke === 1'b0 && cke_fall == lg_cyc[sr_idx] && ref_req === 1'b1,
          "R10 held in self-refresh", cke_fall, lg_cyc[sr_idx]);
    d = cyc; sr_req = 1'b0;
    wait_rq(1'b0, 60); step(1);
    check(cke_rise == d + 1, "R11 clock enable rise", cke_rise, d + 1);
    check(rq_fall == d + 1 + EXITE + TRC, "R11 exit release", rq_fall, d + 1 + EXITE + TRC);
    check(n_log == n0 + 1, "R11 no command during exit", n_log, n0 + 1);
    r = rq_fall;
    wait_rq(1'b1, 200); step(1);
    check(rq_rise >= r + INTV && rq_rise <= r + INTV + 2, "R11 timer restart",
          rq_rise - r, INTV + 1);
    grant(1'b0, a);
    wait_rq(1'b0, 100); step(2);

    check(bad5 == 0, "R5 refresh spacing", bad5, 0);
    check(bad12 == 0, "R12 bus ownership", bad12, 0);
    summary();
    $finish;
  end
endmodule